// File: doc/BRIEF.md
# Clocked Controller for an Asynchronous 32K x 8 Static RAM

This block lets synchronous logic read and write an external asynchronous static RAM of 32,768 bytes. The host issues a single-cycle request with a direction flag (1 = write, 0 = read), a 15-bit word address and, for writes, one data byte. The controller then drives the memory's three active-low strobes (chip select, write enable, output enable), the address bus and the data bus. It reports completion with a one-cycle done pulse, and for a read it also returns the captured byte with a valid pulse.

The memory has no clock, so every minimum time it needs is met by holding pins for a whole number of system clock cycles. Each count is derived from the clock frequency parameter by rounding the nanosecond minimum up, with a floor of one cycle. Three counts are used. The read access count covers 50 ns from the point where the address and strobes are set up until the data is sampled. The write pulse count covers the 45 ns minimum low time of write enable. The recovery count keeps write enable high for at least 5 ns before the next write. The data bus is tri-stated through an explicit drive-enable output. The controller drives it only while output enable is held high, so the memory and the controller never drive the bus at the same time.

Top module: `async_sram_ctrl`

## Requirements
- R1: After reset and whenever idle, mem_cs_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0, and done and rd_valid are 0.
- R2: An accepted read (req_we = 0) holds mem_cs_n = 0, mem_oe_n = 0 and mem_we_n = 1 with a constant address for exactly ACC cycles, where ACC = ceil(50 ns x clock frequency).
- R3: A read accepted at clock edge k is acknowledged in the cycle after edge k+ACC with done = 1 and rd_valid = 1, each for one cycle. rd_data holds the byte present on mem_dq_i at edge k+ACC.
- R4: An accepted write (req_we = 1) holds mem_cs_n = 0 and mem_we_n = 0 for exactly WP cycles, where WP = ceil(45 ns x clock frequency). Address and data stay constant and mem_dq_oe = 1 for the whole pulse.
- R5: After the write pulse, mem_we_n and mem_cs_n return to 1 while data and address stay driven for REC cycles, where REC = ceil(5 ns x clock frequency) and is at least 1. done = 1 and rd_valid = 0 follow in the cycle after edge k+WP+REC.
- R6: mem_oe_n and mem_we_n are never 0 together. mem_dq_oe = 1 only while mem_oe_n = 1, and mem_oe_n is already 1 in the cycle before mem_dq_oe rises.
- R7: A request is accepted only while idle. A req raised during a transfer is ignored: it produces no done and writes no memory.
- R8: Between two consecutive write pulses, mem_we_n stays 1 for at least REC+1 cycles.
- R9: At a 50 MHz clock the cycle counts are ACC = 3, WP = 3 and REC = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Request strobe, sampled while idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| done | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | One-cycle pulse marking rd_data valid (reads only) |
| rd_data | output | 8 | Byte captured by the last read |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 15 | Memory address bus |
| mem_dq_o | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o (1 = drive, 0 = high impedance) |
| mem_dq_i | input | 8 | Data returned by the memory |

## Verification
At the 50 MHz bench clock, a read's done and rd_valid are due 3 edges after the accepting edge, and a write's done is due 3 + 1 edges after it. Pin runs are due as follows: output enable low for 3 cycles, write enable low for 3 cycles, and write enable high for at least 2 cycles between pulses. The driver stamps each accepted request with the edge number plus that latency. The monitor samples on the falling edge and compares the stamp with the current edge count when done appears. The memory model returns a junk byte until the read strobes have been held for the full access window, so sampling too early shows up as a data mismatch.

// File: rtl/asq_pkg.sv
package asq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_READ   = 2'd1,
    ST_WPULSE = 2'd2,
    ST_WREC   = 2'd3
  } asq_state_e;

  // Round a nanosecond minimum up to whole clock cycles, never below one.
  function automatic int ns_to_cyc(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/asq_rst_sync.sv
module asq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/asq_timer.sv
module asq_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/asq_seq.sv
module asq_seq
  import asq_pkg::*;
#(
  parameter int AW      = 15,
  parameter int DW      = 8,
  parameter int ACC_CYC = 5,
  parameter int WP_CYC  = 5,
  parameter int REC_CYC = 1,
  parameter int CW      = 3
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] mem_dq_i,
  input  logic          tmr_expired,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          done,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe
);
  asq_state_e    state_q, state_d;
  logic          cs_n_q, cs_n_d, we_n_q, we_n_d, oe_n_q, oe_n_d;
  logic          dq_oe_q, dq_oe_d, done_q, done_d, rv_q, rv_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q, rdat_q;
  logic          accept, cap_en;

  // Next-state process
  always_comb begin
    state_d  = state_q;
    cs_n_d   = cs_n_q;
    we_n_d   = we_n_q;
    oe_n_d   = oe_n_q;
    dq_oe_d  = dq_oe_q;
    done_d   = 1'b0;
    rv_d     = 1'b0;
    accept   = 1'b0;
    cap_en   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          accept   = 1'b1;
          cs_n_d   = 1'b0;
          tmr_load = 1'b1;
          if (req_we) begin
            we_n_d  = 1'b0;
            dq_oe_d = 1'b1;
            tmr_val = CW'(WP_CYC - 1);
            state_d = ST_WPULSE;
          end else begin
            oe_n_d  = 1'b0;
            tmr_val = CW'(ACC_CYC - 1);
            state_d = ST_READ;
          end
        end
      end
      ST_READ: begin
        if (tmr_expired) begin
          cap_en  = 1'b1;
          done_d  = 1'b1;
          rv_d    = 1'b1;
          cs_n_d  = 1'b1;
          oe_n_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WPULSE: begin
        if (tmr_expired) begin
          we_n_d   = 1'b1;
          cs_n_d   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = CW'(REC_CYC - 1);
          state_d  = ST_WREC;
        end
      end
      ST_WREC: begin
        if (tmr_expired) begin
          dq_oe_d = 1'b0;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Control and strobe registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
      done_q  <= 1'b0;
      rv_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_n_q  <= cs_n_d;
      we_n_q  <= we_n_d;
      oe_n_q  <= oe_n_d;
      dq_oe_q <= dq_oe_d;
      done_q  <= done_d;
      rv_q    <= rv_d;
    end
  end

  // Address and write data, loaded on acceptance only
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      wdat_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
      wdat_q <= req_wdata;
    end
  end

  // Read capture, loaded at the end of the access window
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     rdat_q <= '0;
    else if (cap_en) rdat_q <= mem_dq_i;
  end

  assign mem_cs_n  = cs_n_q;
  assign mem_we_n  = we_n_q;
  assign mem_oe_n  = oe_n_q;
  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdat_q;
  assign mem_dq_oe = dq_oe_q;
  assign done      = done_q;
  assign rd_valid  = rv_q;
  assign rd_data   = rdat_q;

  // Checker state: length of the current write-enable low run
  logic [CW-1:0] wlow_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)                       wlow_q <= '0;
    else if (mem_we_n)                 wlow_q <= '0;
    else if (wlow_q != {CW{1'b1}})     wlow_q <= wlow_q + 1'b1;
  end

  a_r6_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_ni)
    !(!mem_oe_n && !mem_we_n));
  a_r6_drive_only_oe_high: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_dq_oe |-> mem_oe_n);
  a_r6_oe_high_before_drive: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(mem_dq_oe) |-> $past(mem_oe_n));
  a_r4_hold_during_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));
  a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(mem_we_n) |-> (wlow_q >= CW'(WP_CYC)));
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done);
  a_r3_valid_with_done: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_valid |-> done);
  a_r1_idle_after_done: assert property (@(posedge clk) disable iff (!rst_ni)
    done |-> (mem_cs_n && mem_we_n && mem_oe_n));
  a_r7_addr_held: assert property (@(posedge clk) disable iff (!rst_ni)
    !mem_cs_n |=> (mem_cs_n || $stable(mem_addr)));
endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import asq_pkg::*;
#(
  parameter int CLK_MHZ   = 100,
  parameter int AW        = 15,
  parameter int DW        = 8,
  parameter int T_ACC_NS  = 50,
  parameter int T_WP_NS   = 45,
  parameter int T_REC_NS  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);
  localparam int ACC_CYC = ns_to_cyc(T_ACC_NS, CLK_MHZ);
  localparam int WP_CYC  = ns_to_cyc(T_WP_NS, CLK_MHZ);
  localparam int REC_CYC = ns_to_cyc(T_REC_NS, CLK_MHZ);
  localparam int MAX_A   = (ACC_CYC > WP_CYC) ? ACC_CYC : WP_CYC;
  localparam int MAX_CYC = (MAX_A > REC_CYC) ? MAX_A : REC_CYC;
  localparam int CW      = $clog2(MAX_CYC + 1);

  logic          rst_ni;
  logic          tmr_load, tmr_expired;
  logic [CW-1:0] tmr_val;

  asq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  asq_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  asq_seq #(
    .AW(AW), .DW(DW), .ACC_CYC(ACC_CYC), .WP_CYC(WP_CYC),
    .REC_CYC(REC_CYC), .CW(CW)
  ) u_seq (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .req         (req),
    .req_we      (req_we),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .mem_dq_i    (mem_dq_i),
    .tmr_expired (tmr_expired),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .done        (done),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .mem_cs_n    (mem_cs_n),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .mem_addr    (mem_addr),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe   (mem_dq_oe)
  );
endmodule

// File: tb/sim_async_sram_ctrl.sv
module sim_async_sram_ctrl;
  // 50 MHz: 50/20 -> 3, 45/20 -> 3, 5/20 -> 1 (R9)
  localparam int EXP_ACC = 3;
  localparam int EXP_WP  = 3;
  localparam int EXP_REC = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_we = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        done, rd_valid;
  logic [7:0]  rd_data;
  logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [14:0] mem_addr;
  logic [7:0]  mem_dq_o, mem_dq_i;

  always #10 clk = ~clk;

  async_sram_ctrl #(.CLK_MHZ(50)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_cs_n(mem_cs_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // Memory model: junk until the read strobes have been held a full window
  logic [7:0] model_mem [0:32767];
  logic [7:0] shadow    [0:32767];
  int         rd_age = 0;
  logic       rd_on;
  assign rd_on    = !mem_cs_n && !mem_oe_n && mem_we_n;
  assign mem_dq_i = (rd_on && rd_age >= 2) ? model_mem[mem_addr] : 8'h5A;

  always @(posedge clk) begin
    rd_age <= rd_on ? rd_age + 1 : 0;
    if (!mem_cs_n && !mem_we_n && mem_dq_oe) model_mem[mem_addr] <= mem_dq_o;
  end

  int cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  int checks = 0, errors = 0;
  bit mon_on = 1'b0, finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  typedef struct { bit we; logic [7:0] data; int due; } exp_t;
  exp_t q[$];

  // Monitor: scoreboard plus pin-level timing
  bit p_we = 1, p_oe = 1;
  logic [14:0] p_addr = '0;
  logic [7:0]  p_dq = '0;
  int we_low = 0, we_high = 0, oe_low = 0;
  bit seen_pulse = 0;

  always @(negedge clk) if (mon_on) begin
    check(!(!mem_oe_n && !mem_we_n), "R6 oe/we overlap", {mem_oe_n, mem_we_n}, 1);
    check(!mem_dq_oe || mem_oe_n, "R6 drive while oe low", mem_oe_n, 1);
    if (done) begin
      if (q.size() == 0) check(0, "R7 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        check(cyc == e.due, e.we ? "R5/R9 write done cycle" : "R3/R9 read done cycle", cyc, e.due);
        check(rd_valid == !e.we, "R3/R5 rd_valid", rd_valid, !e.we);
        if (!e.we) check(rd_data == e.data, "R3 read data", rd_data, e.data);
      end
    end
    if (p_we && !mem_we_n) begin
      if (seen_pulse) check(we_high >= EXP_REC + 1, "R8 write gap", we_high, EXP_REC + 1);
      check(mem_dq_oe && !mem_cs_n && mem_oe_n, "R4 pulse start pins", {mem_dq_oe, mem_cs_n, mem_oe_n}, 3'b101);
      we_low = 1;
    end else if (!p_we && !mem_we_n) begin
      we_low++;
      check(mem_addr == p_addr && mem_dq_o == p_dq && mem_dq_oe && !mem_cs_n,
            "R4 hold during pulse", mem_addr, p_addr);
    end else if (!p_we && mem_we_n) begin
      check(we_low == EXP_WP, "R4 pulse width", we_low, EXP_WP);
      check(mem_dq_oe && mem_cs_n, "R5 recovery drive", {mem_dq_oe, mem_cs_n}, 2'b11);
      seen_pulse = 1;
      we_high = 1;
    end else we_high++;
    if (!mem_oe_n) begin
      oe_low++;
      check(!mem_cs_n && mem_we_n, "R2 read pins", {mem_cs_n, mem_we_n}, 2'b01);
    end else if (!p_oe) begin
      check(oe_low == EXP_ACC, "R2 read window", oe_low, EXP_ACC);
      oe_low = 0;
    end
    p_we = mem_we_n; p_oe = mem_oe_n; p_addr = mem_addr; p_dq = mem_dq_o;
  end

  task automatic do_op(input bit we, input logic [14:0] a, input logic [7:0] d);
    exp_t e;
    req = 1; req_we = we; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    e.we = we; e.data = we ? 8'h00 : shadow[a];
    e.due = cyc + (we ? EXP_WP + EXP_REC : EXP_ACC);
    q.push_back(e);
    if (we) shadow[a] = d;
    @(negedge clk); req = 0;
    while (!done) @(negedge clk);
  endtask

  // Read of ra with a write request to wa raised while busy (R7)
  task automatic read_with_noise(input logic [14:0] ra, input logic [14:0] wa, input logic [7:0] wd);
    exp_t e;
    req = 1; req_we = 0; req_addr = ra;
    @(posedge clk); #1;
    e.we = 0; e.data = shadow[ra]; e.due = cyc + EXP_ACC;
    q.push_back(e);
    @(negedge clk); req_we = 1; req_addr = wa; req_wdata = wd;
    @(negedge clk);
    @(negedge clk); req = 0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 32768; i++) begin
      model_mem[i] = 8'(i) ^ 8'h3C;
      shadow[i]    = 8'(i) ^ 8'h3C;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes idle", {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
    check(!mem_dq_oe && !done && !rd_valid, "R1 bus released", {mem_dq_oe, done, rd_valid}, 0);
    mon_on = 1;
    // Back-to-back writes (R4, R5, R8)
    do_op(1, 15'h0000, 8'h11);
    do_op(1, 15'h7FFF, 8'hEE);
    do_op(1, 15'h1234, 8'hA5);
    do_op(1, 15'h4321, 8'h00);
    // Reads back (R2, R3)
    do_op(0, 15'h0000, 8'h00);
    do_op(0, 15'h7FFF, 8'h00);
    do_op(0, 15'h1234, 8'h00);
    do_op(0, 15'h4321, 8'h00);
    do_op(0, 15'h0042, 8'h00);
    // Overwrite, then read twice in a row
    do_op(1, 15'h1234, 8'hFF);
    do_op(0, 15'h1234, 8'h00);
    do_op(0, 15'h1234, 8'h00);
    // Write then read mixes
    do_op(0, 15'h2000, 8'h00);
    do_op(1, 15'h2000, 8'h3C);
    do_op(0, 15'h2000, 8'h00);
    // Ignored request while busy (R7): 0x0042 must keep its old value
    read_with_noise(15'h0000, 15'h0042, 8'h99);
    do_op(0, 15'h0042, 8'h00);
    repeat (6) @(negedge clk);
    check(q.size() == 0, "R7 every request acknowledged once", q.size(), 0);
    check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 idle at end",
          {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule